// File: doc/BRIEF.md
# Detection Timer and Alarm Controller

This block paces a cell-protection monitor and drives its fault alarm. It issues a one-cycle detection tick at a slow rate in normal operation and at a four-times faster rate in quick test mode. The downstream overvoltage and open-wire detectors advance on that tick. Quick test mode is entered and left through two supply comparator flags. One flag says the supply sits far above the top cell input. The other says it has come down close to it. Between the two thresholds the current mode is kept.

A sleep request halts the tick and clears the prescaler. While asleep, the alarm is forced to its asserted level. When sleep is released, the tick restarts from a fresh period. The active-low alarm pin is presented as a data bit and an output-enable bit, so the pad can be push-pull, sink-only open drain or source-only open drain. The style is selected by a two-bit setting. The alarm is asserted whenever the overvoltage flag or the open-wire flag is high. The sleep request and both comparator flags are asynchronous and pass through two-flop synchronizers. The fault flags and the style setting come from the block's own clock domain.

Top module: `cell_watch_timer`

## Requirements
- R1: In normal mode `det_tick` pulses high for exactly one cycle every NORM_MS milliseconds, that is CLK_HZ*NORM_MS/1000 clock cycles.
- R2: In quick mode `det_tick` pulses high for one cycle every CLK_HZ*QUICK_MS/1000 cycles.
- R3: A synchronized high on `supply_hi_cmp` sets `quick_mode` one cycle later. When both comparator flags are high, entry wins.
- R4: A synchronized high on `supply_lo_cmp` with `supply_hi_cmp` low clears `quick_mode` one cycle later. With both flags low, the mode is unchanged.
- R5: When `quick_mode` changes, the prescaler restarts. The first tick in the new mode comes exactly one new period after the edge at which `quick_mode` changed.
- R6: While `sleep_active` is high, no tick is produced. The first tick after sleep ends comes one full period after `sleep_active` falls.
- R7: The alarm is asserted one cycle after `ov_fault` or `ow_fault` is high, and also one cycle after `sleep_active` is high.
- R8: With `drive_style` 0 (push-pull) or 3 (treated as push-pull), `alarm_oe` is 1. `alarm_o` is 0 when asserted and 1 otherwise.
- R9: With `drive_style` 1 (sink open drain), `alarm_o` is 0. `alarm_oe` equals the asserted state.
- R10: With `drive_style` 2 (source open drain), `alarm_o` is 1. `alarm_oe` equals the asserted state.
- R11: During reset, `det_tick`, `quick_mode`, `sleep_active`, `alarm_o` and `alarm_oe` are all 0, so the alarm pad is released.
- R12: `sleep_req`, `supply_hi_cmp` and `supply_lo_cmp` pass through two flops. `sleep_active` follows `sleep_req` two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, high = sleep |
| supply_hi_cmp | input | 1 | Asynchronous flag: supply far above top cell (enter quick mode) |
| supply_lo_cmp | input | 1 | Asynchronous flag: supply close to top cell (leave quick mode) |
| ov_fault | input | 1 | Overvoltage fault flag |
| ow_fault | input | 1 | Open-wire fault flag |
| drive_style | input | 2 | Alarm pad style: 0 push-pull, 1 sink open drain, 2 source open drain, 3 push-pull |
| det_tick | output | 1 | One-cycle detection tick |
| quick_mode | output | 1 | Quick test mode indicator |
| sleep_active | output | 1 | Synchronized sleep indicator |
| alarm_o | output | 1 | Alarm pad data |
| alarm_oe | output | 1 | Alarm pad output enable |

## Verification
Each result has a fixed latency:
- `sleep_active` appears two cycles after a change on `sleep_req`.
- `quick_mode` reacts three cycles after a comparator flag.
- The alarm pair follows a fault flag or a style change by one cycle, and a sleep request by three.
- A tick lands exactly one period after the last edge at which `quick_mode` or `sleep_active` changed, or after reset was released.

The bench model advances a delay line and an age counter on each rising edge. It compares all five outputs on each falling edge, so every expectation is read one half cycle after the edge that produced it. Stimulus toggles the modes partway through a period, so the restart rule is tested separately from the steady tick rate.

// File: rtl/cwt_pkg.sv
// Shared types for the detection timer and alarm controller.
package cwt_pkg;

    // Alarm pad drive style selected by the two-bit setting.
    typedef enum logic [1:0] {
        DRV_PUSHPULL = 2'd0,
        DRV_SINK     = 2'd1,
        DRV_SOURCE   = 2'd2,
        DRV_SPARE    = 2'd3
    } drive_style_e;

endpackage

// File: rtl/cwt_sync.sv
// Two-flop synchronizer for WIDTH independent asynchronous bits.
// Assumes each bit is a slow level; no bus coherence is promised.
module cwt_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Purpose: shift the asynchronous levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;

endmodule

// File: rtl/cwt_mode.sv
// Hysteretic quick-test mode register.
// Entry flag wins over exit flag; with neither flag the mode is held.
// Assumes both flags are already synchronized.
module cwt_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_flag,
    input  logic leave_flag,
    output logic quick_q,
    output logic mode_flip
);

    logic quick_d;

    // Purpose: pick the next mode from the two comparator flags.
    always_comb begin
        if (enter_flag) begin
            quick_d = 1'b1;
        end else if (leave_flag) begin
            quick_d = 1'b0;
        end else begin
            quick_d = quick_q;
        end
    end

    // Purpose: hold the current mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quick_q <= 1'b0;
        end else begin
            quick_q <= quick_d;
        end
    end

    assign mode_flip = quick_d ^ quick_q;

    AST_ENTER_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        enter_flag |=> quick_q); // R3
    AST_LEAVE_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        (leave_flag && !enter_flag) |=> !quick_q); // R4
    AST_HOLD_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!leave_flag && !enter_flag) |=> $stable(quick_q)); // R4

endmodule

// File: rtl/cwt_prescaler.sv
// Detection tick prescaler with two selectable periods.
// A restart clears the count so the next tick is one full period away.
// Assumes both periods are at least two cycles.
module cwt_prescaler #(
    parameter int NORM_CYC  = 400,
    parameter int QUICK_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic quick,
    input  logic restart,
    output logic tick_q
);

    localparam int MAX_CYC = (NORM_CYC > QUICK_CYC) ? NORM_CYC : QUICK_CYC;
    localparam int CW      = $clog2(MAX_CYC);
    localparam logic [CW-1:0] NORM_LAST  = CW'(NORM_CYC - 1);
    localparam logic [CW-1:0] QUICK_LAST = CW'(QUICK_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_w;

    // Purpose: choose the terminal count for the current mode.
    always_comb begin
        last_w = quick ? QUICK_LAST : NORM_LAST;
    end

    // Purpose: count cycles and pulse the tick at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == last_w) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q); // R1
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick_q); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_w); // R2

endmodule

// File: rtl/cwt_alarm.sv
// Registered alarm pad encoder.
// Asserted on either fault or while asleep. Drives data and enable per
// pad style. Assumes the fault flags and style are synchronous to clk.
module cwt_alarm
    import cwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] style,
    input  logic       ov_flag,
    input  logic       ow_flag,
    input  logic       sleep_s,
    output logic       pad_o,
    output logic       pad_oe
);

    logic asserted_w;
    logic pad_o_d;
    logic pad_oe_d;

    assign asserted_w = ov_flag | ow_flag | sleep_s;

    // Purpose: map the asserted state onto the pad style.
    always_comb begin
        case (style)
            DRV_SINK: begin
                pad_o_d  = 1'b0;
                pad_oe_d = asserted_w;
            end
            DRV_SOURCE: begin
                pad_o_d  = 1'b1;
                pad_oe_d = asserted_w;
            end
            default: begin
                pad_o_d  = ~asserted_w;
                pad_oe_d = 1'b1;
            end
        endcase
    end

    // Purpose: register the pad pair; released during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_o  <= 1'b0;
            pad_oe <= 1'b0;
        end else begin
            pad_o  <= pad_o_d;
            pad_oe <= pad_oe_d;
        end
    end

    AST_ALARM_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_flag || ow_flag || sleep_s) |=> pad_oe); // R7
    AST_PUSHPULL_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (style == DRV_PUSHPULL || style == DRV_SPARE) |=> pad_oe); // R8
    AST_SINK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (style == DRV_SINK) |=> !pad_o); // R9
    AST_SOURCE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (style == DRV_SOURCE) |=> pad_o); // R10

endmodule

// File: rtl/cell_watch_timer.sv
// Detection timer and alarm controller, top level.
// Synchronizes sleep and supply comparator flags, keeps the hysteretic
// quick mode, paces the detection tick and drives the alarm pad pair.
// Assumes CLK_HZ*QUICK_MS/1000 >= 2.
module cell_watch_timer #(
    parameter int CLK_HZ   = 32768,
    parameter int NORM_MS  = 400,
    parameter int QUICK_MS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       supply_hi_cmp,
    input  logic       supply_lo_cmp,
    input  logic       ov_fault,
    input  logic       ow_fault,
    input  logic [1:0] drive_style,
    output logic       det_tick,
    output logic       quick_mode,
    output logic       sleep_active,
    output logic       alarm_o,
    output logic       alarm_oe
);

    localparam int NORM_CYC  = CLK_HZ * NORM_MS / 1000;
    localparam int QUICK_CYC = CLK_HZ * QUICK_MS / 1000;
    localparam int SYNC_W    = 3;

    logic [SYNC_W-1:0] sync_in;
    logic [SYNC_W-1:0] sync_out;
    logic              sleep_s;
    logic              hi_s;
    logic              lo_s;
    logic              mode_flip;

    assign sync_in = {sleep_req, supply_hi_cmp, supply_lo_cmp};
    assign sleep_s = sync_out[2];
    assign hi_s    = sync_out[1];
    assign lo_s    = sync_out[0];

    cwt_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sync_in),
        .d_sync  (sync_out)
    );

    cwt_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_flag (hi_s),
        .leave_flag (lo_s),
        .quick_q    (quick_mode),
        .mode_flip  (mode_flip)
    );

    cwt_prescaler #(
        .NORM_CYC  (NORM_CYC),
        .QUICK_CYC (QUICK_CYC)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .quick   (quick_mode),
        .restart (mode_flip | sleep_s),
        .tick_q  (det_tick)
    );

    cwt_alarm u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .style   (drive_style),
        .ov_flag (ov_fault),
        .ow_flag (ow_fault),
        .sleep_s (sleep_s),
        .pad_o   (alarm_o),
        .pad_oe  (alarm_oe)
    );

    assign sleep_active = sleep_s;

    AST_SLEEP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active && $past(sleep_active)) |-> !det_tick); // R6

endmodule

// File: tb/cell_watch_timer_bench.sv
`timescale 1ns/1ps
module cell_watch_timer_bench;

    localparam int CLK_HZ = 1000;
    localparam int NP     = 400;  // normal period in cycles at 1 kHz
    localparam int QP     = 100;  // quick period in cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       supply_hi_cmp = 1'b0;
    logic       supply_lo_cmp = 1'b0;
    logic       ov_fault = 1'b0;
    logic       ow_fault = 1'b0;
    logic [1:0] drive_style = 2'd0;
    logic       det_tick;
    logic       quick_mode;
    logic       sleep_active;
    logic       alarm_o;
    logic       alarm_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cell_watch_timer #(.CLK_HZ(CLK_HZ), .NORM_MS(400), .QUICK_MS(100)) u_cell_watch_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_req     (sleep_req),
        .supply_hi_cmp (supply_hi_cmp),
        .supply_lo_cmp (supply_lo_cmp),
        .ov_fault      (ov_fault),
        .ow_fault      (ow_fault),
        .drive_style   (drive_style),
        .det_tick      (det_tick),
        .quick_mode    (quick_mode),
        .sleep_active  (sleep_active),
        .alarm_o       (alarm_o),
        .alarm_oe      (alarm_oe)
    );

    // Reference model: delay line for the flags, mode, tick age, alarm.
    logic [2:0] m_line [0:1];
    logic       m_quick;
    logic       m_nq;
    int         m_age;
    int         m_kind;   // 0 reset, 1 mode change, 2 sleep
    logic       m_av;
    logic       m_asrt;
    logic [1:0] m_sty;
    logic       m_rst_seen;

    always_comb begin
        if (m_line[1][1])      m_nq = 1'b1;
        else if (m_line[1][0]) m_nq = 1'b0;
        else                   m_nq = m_quick;
    end

    always @(posedge clk) begin
        m_rst_seen <= !rst_n;
        if (!rst_n) begin
            m_line[0] <= 3'b000;
            m_line[1] <= 3'b000;
            m_quick   <= 1'b0;
            m_age     <= 0;
            m_kind    <= 0;
            m_av      <= 1'b0;
            m_asrt    <= 1'b0;
            m_sty     <= 2'd0;
        end else begin
            m_line[0] <= {sleep_req, supply_hi_cmp, supply_lo_cmp};
            m_line[1] <= m_line[0];
            m_quick   <= m_nq;
            if (m_nq != m_quick) begin
                m_age  <= 0;
                m_kind <= 1;
            end else if (m_line[1][2]) begin
                m_age  <= 0;
                m_kind <= 2;
            end else begin
                m_age <= m_age + 1;
            end
            m_av   <= 1'b1;
            m_asrt <= ov_fault | ow_fault | m_line[1][2];
            m_sty  <= drive_style;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output on each falling edge.
    always @(negedge clk) begin
        if (m_rst_seen) begin
            check(det_tick == 0 && quick_mode == 0 && sleep_active == 0 &&
                  alarm_o == 0 && alarm_oe == 0, "R11", "reset outputs",
                  {det_tick, quick_mode, sleep_active, alarm_o, alarm_oe}, 0);
        end else if (m_av) begin
            int per;
            bit exp_tick;
            bit exp_o;
            bit exp_oe;
            string ttag;
            string atag;
            per = m_quick ? QP : NP;
            exp_tick = (m_age > 0) && (m_age % per == 0);
            if (m_kind == 1 && m_age <= per)      ttag = "R5";
            else if (m_kind == 2 && m_age <= per) ttag = "R6";
            else if (m_quick)                     ttag = "R2";
            else                                  ttag = "R1";
            check(det_tick == exp_tick, ttag, "det_tick", det_tick, exp_tick);
            check(quick_mode == m_quick, m_quick ? "R3" : "R4", "quick_mode",
                  quick_mode, m_quick);
            check(sleep_active == m_line[1][2], "R12", "sleep_active",
                  sleep_active, m_line[1][2]);
            case (m_sty)
                2'd1: begin exp_o = 1'b0; exp_oe = m_asrt; atag = "R9"; end
                2'd2: begin exp_o = 1'b1; exp_oe = m_asrt; atag = "R10"; end
                default: begin exp_o = !m_asrt; exp_oe = 1'b1; atag = "R8"; end
            endcase
            check(alarm_o == exp_o && alarm_oe == exp_oe,
                  m_asrt ? "R7" : atag, "alarm pair",
                  {alarm_o, alarm_oe}, {exp_o, exp_oe});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(900);                              // R1 normal ticks
        ov_fault = 1'b1; step(20);              // R7 R8 push-pull asserted
        ov_fault = 1'b0; ow_fault = 1'b1; drive_style = 2'd1; step(20); // R9
        ow_fault = 1'b0; step(10);
        drive_style = 2'd2; step(5);            // R10 idle released
        ov_fault = 1'b1; step(10);
        ov_fault = 1'b0; step(10);
        drive_style = 2'd3; ow_fault = 1'b1; step(10); // R8 spare code
        ow_fault = 1'b0; drive_style = 2'd0; step(57);
        supply_hi_cmp = 1'b1; step(6);          // R3 entry mid-period
        supply_hi_cmp = 1'b0; step(350);        // R2 R5 held in quick
        supply_lo_cmp = 1'b1; step(6);          // R4 exit
        supply_lo_cmp = 1'b0; step(600);
        supply_hi_cmp = 1'b1; supply_lo_cmp = 1'b1; step(6); // R3 entry wins
        supply_hi_cmp = 1'b0; step(6);          // R4 exit with lo only
        supply_lo_cmp = 1'b0; step(500);
        sleep_req = 1'b1; step(60);             // R6 R7 R12 sleep
        sleep_req = 1'b0; step(450);
        drive_style = 2'd1; sleep_req = 1'b1; step(30); // R9 asleep
        sleep_req = 1'b0; drive_style = 2'd0; step(20);
        supply_hi_cmp = 1'b1; step(5);
        supply_hi_cmp = 1'b0; step(150);
        sleep_req = 1'b1; step(30);             // sleep in quick mode
        sleep_req = 1'b0; step(250);
        supply_lo_cmp = 1'b1; step(5);
        supply_lo_cmp = 1'b0; step(450);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule